// File: doc/BRIEF.md
# Compare Timer with 64-bit Free-Running Counter

This block is a free-running 64-bit up-counter with a programmable clock divider and one 64-bit comparator. Software reaches it through a plain 32-bit register bus. A bus cycle carries an address, a write enable with write data, and a read strobe. Read data comes back one clock after the strobe. Software reads the counter as two 32-bit halves. Reading the low half captures the high half at the same instant, so a low-then-high read pair forms one consistent 64-bit sample.

The comparator sets a sticky event flag once the counter reaches or passes the programmed value. The event flag drives an interrupt line that software can mask. An optional reload adds a 32-bit step to the comparator on every match, which gives periodic events without any software action. The live counter value is also brought out as a port for neighbouring logic.

Register byte offsets:
- 0x00: counter low word.
- 0x04: counter high word.
- 0x08: control.
- 0x0C: status.
- 0x10: comparator low word.
- 0x14: comparator high word.
- 0x18: reload step.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the counter, the comparator, the reload step, the control and status registers all read zero, and `irqOut` is low.
- R2: While control bit 0 (run) is set, the counter increases by one once every P+1 clocks, where P is control bits [15:8]. While the run bit is clear, the counter holds its value.
- R3: Control keeps bit 0 (run), bit 1 (compare enable), bit 2 (interrupt enable), bit 3 (reload enable) and bits [15:8] (divider P). All other bits read back as zero, and one write updates the enable bits and the divider field together.
- R4: A write to the counter low word (0x00) or high word (0x04) loads that half only while the run bit is clear. While the run bit is set, such a write is ignored.
- R5: A read strobe returns data on `busRdata` one clock later. Reading 0x00 captures the current high half, and a later read of 0x04 returns that captured value rather than the live one.
- R6: When the run bit and the compare-enable bit are both set and the counter is greater than or equal to the 64-bit comparator, the event flag (status bit 0 at 0x0C) is set at the next clock.
- R7: While the compare-enable bit is clear, the event flag is never set, whatever the counter and comparator values.
- R8: The event flag stays set until a write of 1 to status bit 0. Writing 0 to it has no effect, and a new match in the same cycle as a clear wins over the clear.
- R9: `irqOut` is high exactly when the event flag is set and control bit 2 is set.
- R10: On a match with control bit 3 set, the comparator is loaded with its old value plus the reload step, producing a new event after every step of counts.
- R11: Reads of the comparator words, reload step and status return their stored values, and a read of any unmapped offset (for example 0x1C) returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte offset of the register |
| busWe | input | 1 | Write enable, one clock per write |
| busWdata | input | 32 | Write data |
| busRe | input | 1 | Read strobe, one clock per read |
| busRdata | output | 32 | Read data, valid the clock after the strobe |
| irqOut | output | 1 | Interrupt, event flag masked by the interrupt enable |
| countOut | output | 64 | Live counter value |

## Verification
The assertions take for granted that software never writes a comparator word while the comparator is both enabled and matching. Under that assumption the reload check is not disturbed by a direct load. The counter-step checks rely on the counter being loaded only while stopped, so a running counter moves by at most one per clock.

The bench keeps to this discipline: it clears the run and compare bits before reloading the counter or the comparator. Every bus cycle lasts one clock and is driven between clock edges.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;
  parameter int BUS_W  = 32;
  parameter int PSC_W  = 8;
  parameter int ADDR_W = 5;
  localparam int CNT_W = 2 * BUS_W;

  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_CMP_LO = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_CMP_HI = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_STEP   = 5'h18;

  localparam int CTL_RUN  = 0;
  localparam int CTL_CMP  = 1;
  localparam int CTL_IRQ  = 2;
  localparam int CTL_AUTO = 3;
  localparam int CTL_PSC  = 8;

  // write strobes from the register decode to the datapath
  typedef struct packed {
    logic             wrCntLo;
    logic             wrCntHi;
    logic             wrCmpLo;
    logic             wrCmpHi;
    logic             wrStep;
    logic [BUS_W-1:0] data;
  } dpStrobe_t;

  // static configuration held by the control register
  typedef struct packed {
    logic             runEn;
    logic             cmpEn;
    logic             autoEn;
    logic [PSC_W-1:0] psc;
  } dpCfg_t;
endpackage

// File: rtl/tick_cmp_dp.sv
module tick_cmp_dp
  import tick_cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpCfg_t           cfg,
  input  dpStrobe_t        strb,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmpVal,
  output logic [BUS_W-1:0] stepVal,
  output logic             matchEvt
);
  logic [PSC_W-1:0] pscCnt;
  logic             tick;
  logic [CNT_W-1:0] stepExt;

  assign tick     = cfg.runEn && (pscCnt == cfg.psc);
  assign stepExt  = {{(CNT_W-BUS_W){1'b0}}, stepVal};
  assign matchEvt = cfg.runEn && cfg.cmpEn && (count >= cmpVal);

  // divider: counts input clocks, restarts from zero whenever stopped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pscCnt <= '0;
    end else if (!cfg.runEn || tick) begin
      pscCnt <= '0;
    end else begin
      pscCnt <= pscCnt + 1'b1;
    end
  end

  // main counter: loadable by halves only while stopped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (!cfg.runEn) begin
      if (strb.wrCntLo) count[BUS_W-1:0]     <= strb.data;
      if (strb.wrCntHi) count[CNT_W-1:BUS_W] <= strb.data;
    end else if (tick) begin
      count <= count + 1'b1;
    end
  end

  // comparator: direct load wins over the automatic reload
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpVal <= '0;
    end else if (strb.wrCmpLo || strb.wrCmpHi) begin
      if (strb.wrCmpLo) cmpVal[BUS_W-1:0]     <= strb.data;
      if (strb.wrCmpHi) cmpVal[CNT_W-1:BUS_W] <= strb.data;
    end else if (matchEvt && cfg.autoEn) begin
      cmpVal <= cmpVal + stepExt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepVal <= '0;
    end else if (strb.wrStep) begin
      stepVal <= strb.data;
    end
  end

  // R2: a running counter moves by zero or one per clock
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfg.runEn |=> (count == $past(count)) || (count == $past(count) + 1'b1));

  // R2, R4: a stopped counter without a load keeps its value
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.runEn && !strb.wrCntLo && !strb.wrCntHi) |=> $stable(count));

  // R10: reload adds the step on a match
  p_reload_r10: assert property (@(posedge clk) disable iff (!rstN)
    (matchEvt && cfg.autoEn && !strb.wrCmpLo && !strb.wrCmpHi)
      |=> cmpVal == $past(cmpVal) + $past(stepExt));
endmodule

// File: rtl/tick_cmp_ctrl.sv
module tick_cmp_ctrl
  import tick_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic              busRe,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irqOut,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  cmpVal,
  input  logic [BUS_W-1:0]  stepVal,
  input  logic              matchEvt,
  output dpCfg_t            cfg,
  output dpStrobe_t         strb
);
  logic             irqEn;
  logic             evtFlag;
  logic             clrReq;
  logic [BUS_W-1:0] hiLatch;
  logic [BUS_W-1:0] rdNext;
  logic [BUS_W-1:0] ctrlView;

  // strobes to the datapath
  always_comb begin
    strb         = '0;
    strb.data    = busWdata;
    strb.wrCntLo = busWe && (busAddr == OFF_CNT_LO);
    strb.wrCntHi = busWe && (busAddr == OFF_CNT_HI);
    strb.wrCmpLo = busWe && (busAddr == OFF_CMP_LO);
    strb.wrCmpHi = busWe && (busAddr == OFF_CMP_HI);
    strb.wrStep  = busWe && (busAddr == OFF_STEP);
  end

  // control register: enables and divider written together
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg   <= '0;
      irqEn <= 1'b0;
    end else if (busWe && (busAddr == OFF_CTRL)) begin
      cfg.runEn  <= busWdata[CTL_RUN];
      cfg.cmpEn  <= busWdata[CTL_CMP];
      cfg.autoEn <= busWdata[CTL_AUTO];
      cfg.psc    <= busWdata[CTL_PSC +: PSC_W];
      irqEn      <= busWdata[CTL_IRQ];
    end
  end

  // sticky event flag, a new match outranks a clear
  assign clrReq = busWe && (busAddr == OFF_STAT) && busWdata[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtFlag <= 1'b0;
    end else if (matchEvt) begin
      evtFlag <= 1'b1;
    end else if (clrReq) begin
      evtFlag <= 1'b0;
    end
  end

  assign irqOut = evtFlag && irqEn;

  always_comb begin
    ctrlView                     = '0;
    ctrlView[CTL_RUN]            = cfg.runEn;
    ctrlView[CTL_CMP]            = cfg.cmpEn;
    ctrlView[CTL_IRQ]            = irqEn;
    ctrlView[CTL_AUTO]           = cfg.autoEn;
    ctrlView[CTL_PSC +: PSC_W]   = cfg.psc;
  end

  always_comb begin
    case (busAddr)
      OFF_CNT_LO: rdNext = count[BUS_W-1:0];
      OFF_CNT_HI: rdNext = hiLatch;
      OFF_CTRL:   rdNext = ctrlView;
      OFF_STAT:   rdNext = {{(BUS_W-1){1'b0}}, evtFlag};
      OFF_CMP_LO: rdNext = cmpVal[BUS_W-1:0];
      OFF_CMP_HI: rdNext = cmpVal[CNT_W-1:BUS_W];
      OFF_STEP:   rdNext = stepVal;
      default:    rdNext = '0;
    endcase
  end

  // registered read port with high-half capture on a low-half read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
      hiLatch  <= '0;
    end else if (busRe) begin
      busRdata <= rdNext;
      if (busAddr == OFF_CNT_LO) hiLatch <= count[CNT_W-1:BUS_W];
    end
  end

  // R8: the flag only drops on a clear request
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (evtFlag && !clrReq) |=> evtFlag);

  // R7: with compare disabled the flag cannot rise
  p_cmp_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.cmpEn && !evtFlag) |=> !evtFlag);

  // R6: the flag rises only after a match from the datapath
  p_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!evtFlag && !matchEvt) |=> !evtFlag);
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tick_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic              busRe,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irqOut,
  output logic [CNT_W-1:0]  countOut
);
  dpCfg_t           cfg;
  dpStrobe_t        strb;
  logic [CNT_W-1:0] cmpVal;
  logic [BUS_W-1:0] stepVal;
  logic             matchEvt;

  tick_cmp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .busRe    (busRe),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .count    (countOut),
    .cmpVal   (cmpVal),
    .stepVal  (stepVal),
    .matchEvt (matchEvt),
    .cfg      (cfg),
    .strb     (strb)
  );

  tick_cmp_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .strb     (strb),
    .count    (countOut),
    .cmpVal   (cmpVal),
    .stepVal  (stepVal),
    .matchEvt (matchEvt)
  );
endmodule

// File: tb/tick_cmp_timer_bench.sv
module tick_cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic        irqOut;
  logic [63:0] countOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  tick_cmp_timer u_tick_cmp_timer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata),
    .irqOut(irqOut), .countOut(countOut)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one-clock write; the register updates at the posedge inside
  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    busAddr = a; busRe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic zeroCounter();
    busWrite(5'h08, 32'h0);
    busWrite(5'h00, 32'h0);
    busWrite(5'h04, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 count", countOut, 64'h0);
    check("R1 irq", {63'h0, irqOut}, 64'h0);
    busRead(5'h08, d); check("R1 ctrl", {32'h0, d}, 64'h0);
    busRead(5'h0C, d); check("R1 status", {32'h0, d}, 64'h0);
    busRead(5'h14, d); check("R1 cmp hi", {32'h0, d}, 64'h0);
    busRead(5'h18, d); check("R1 step", {32'h0, d}, 64'h0);
  endtask

  task automatic t_prescale();
    zeroCounter();
    busWrite(5'h08, 32'h0000_0301);
    waitEdges(20);
    check("R2 divide by 4", countOut, 64'd5);
    busWrite(5'h08, 32'h0000_0300);
    waitEdges(10);
    check("R2 hold when stopped", countOut, 64'd5);
    zeroCounter();
    busWrite(5'h08, 32'h0000_0001);
    waitEdges(7);
    check("R2 divide by 1", countOut, 64'd7);
  endtask

  task automatic t_cntLock();
    logic [31:0] d;
    zeroCounter();
    busWrite(5'h08, 32'h0000_FF01);
    busWrite(5'h00, 32'h0000_ABCD);
    waitEdges(5);
    check("R4 write ignored while running", countOut, 64'h0);
    busRead(5'h08, d); check("R3 ctrl readback", {32'h0, d}, 64'h0000_FF01);
    busWrite(5'h08, 32'h0);
    busWrite(5'h00, 32'h1234_5678);
    busWrite(5'h04, 32'h0000_0009);
    check("R4 load while stopped", countOut, 64'h0000_0009_1234_5678);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    busWrite(5'h04, 32'h11);
    busWrite(5'h00, 32'h22);
    busRead(5'h00, d); check("R5 low read", {32'h0, d}, 64'h22);
    busWrite(5'h04, 32'h33);
    busRead(5'h04, d); check("R5 captured high", {32'h0, d}, 64'h11);
    busRead(5'h00, d);
    busRead(5'h04, d); check("R5 fresh high", {32'h0, d}, 64'h33);
  endtask

  task automatic t_compare();
    logic [31:0] d;
    zeroCounter();
    busWrite(5'h10, 32'd10);
    busWrite(5'h14, 32'd0);
    busWrite(5'h08, 32'h0000_0007);
    waitEdges(10);
    check("R6 count at threshold", countOut, 64'd10);
    check("R6 no event yet", {63'h0, irqOut}, 64'h0);
    waitEdges(1);
    check("R6 event on reach", {63'h0, irqOut}, 64'h1);
    busWrite(5'h08, 32'h0000_0003);
    check("R9 irq masked", {63'h0, irqOut}, 64'h0);
    busRead(5'h0C, d); check("R9 flag kept under mask", {32'h0, d}, 64'h1);
    busWrite(5'h08, 32'h0000_0007);
    check("R9 irq unmasked", {63'h0, irqOut}, 64'h1);
    busWrite(5'h08, 32'h0000_0001);
    busWrite(5'h0C, 32'h0);
    busRead(5'h0C, d); check("R8 write 0 ignored", {32'h0, d}, 64'h1);
    busWrite(5'h0C, 32'h1);
    busRead(5'h0C, d); check("R8 write 1 clears", {32'h0, d}, 64'h0);
    waitEdges(10);
    busRead(5'h0C, d); check("R7 no event with compare off", {32'h0, d}, 64'h0);
    // R8: clear while compare keeps matching, the match wins
    busWrite(5'h08, 32'h0000_0003);
    busWrite(5'h0C, 32'h1);
    busRead(5'h0C, d); check("R8 match beats clear", {32'h0, d}, 64'h1);
  endtask

  task automatic t_auto();
    logic [31:0] d;
    zeroCounter();
    busWrite(5'h10, 32'd5);
    busWrite(5'h14, 32'd0);
    busWrite(5'h18, 32'd8);
    busWrite(5'h0C, 32'h1);
    busWrite(5'h08, 32'h0000_000F);
    waitEdges(8);
    check("R10 first event", {63'h0, irqOut}, 64'h1);
    busWrite(5'h08, 32'h0);
    check("R10 count at stop", countOut, 64'd9);
    busRead(5'h10, d); check("R10 reload once", {32'h0, d}, 64'd13);
    busWrite(5'h0C, 32'h1);
    busRead(5'h0C, d); check("R8 cleared", {32'h0, d}, 64'h0);
    busWrite(5'h08, 32'h0000_000F);
    waitEdges(4);
    check("R10 before second event", {63'h0, irqOut}, 64'h0);
    waitEdges(1);
    check("R10 second event", {63'h0, irqOut}, 64'h1);
    busWrite(5'h08, 32'h0);
    busRead(5'h10, d); check("R10 reload twice", {32'h0, d}, 64'd21);
  endtask

  task automatic t_map();
    logic [31:0] d;
    busWrite(5'h08, 32'hFFFF_FFFE);
    busRead(5'h08, d); check("R3 unused ctrl bits zero", {32'h0, d}, 64'h0000_FF0E);
    busWrite(5'h08, 32'h0);
    busRead(5'h1C, d); check("R11 unmapped reads zero", {32'h0, d}, 64'h0);
    busWrite(5'h18, 32'h0000_DEAD);
    busRead(5'h18, d); check("R11 step readback", {32'h0, d}, 64'h0000_DEAD);
    busWrite(5'h14, 32'h77);
    busRead(5'h14, d); check("R11 cmp hi readback", {32'h0, d}, 64'h77);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_cntLock();
    t_latch();
    t_compare();
    t_auto();
    t_map();
    finishRun();
  end
endmodule